// File: doc/BRIEF.md
# Multi-Channel Numerically Controlled Base-Clock Generator

This block holds one numerically controlled oscillator per channel, all running on the reference clock. Each channel keeps a 16-bit phase accumulator that advances by an effective step every reference cycle. The channel's output is the most significant bit of that accumulator. The output frequency is therefore step × f_ref / 65536.

Each channel also emits a strobe that is one reference cycle wide whenever its output rises. A later constant-frequency stage uses this strobe as its base clock.

Software programs each channel with a 16-bit control word. The word is written one byte at a time through a simple write port, and each byte has its own address. Words at or above 0x8000 are treated as negative: the accumulator advances by their 16-bit two's complement, so those words also give low frequencies. Power-of-two words give an exact half-high, half-low output.

Top module: `nco_bank`

## Requirements
- R1: The effective step of a channel equals its control word when bit 15 of the word is 0. Otherwise it equals (65536 − word) mod 65536. As examples, 0xFF00 steps by 0x0100, 0xFFFF steps by 1, and 0x8000 steps by 0x8000.
- R2: After reset every control word and every accumulator is zero, and all outputs are 0. On every clock edge each accumulator adds its effective step modulo 65536. `freq_out[n]` shows bit 15 of the updated accumulator in the cycle after that edge.
- R3: A write with `wr_en` high to byte address 0x08 + 8·n loads `wr_data` into bits 15:8 of channel n's word. A write to 0x0C + 8·n loads bits 7:0. The other byte of that word keeps its value.
- R4: A write to any address that R3 does not map changes no control word, so no output is affected.
- R5: `tick[n]` is high for exactly the one cycle in which `freq_out[n]` has just changed from 0 to 1, and it is low at all other times.
- R6: While a channel's effective step is 0, its `freq_out` does not change and its `tick` stays low.
- R7: A power-of-two effective step W gives a period of 65536/W cycles with exactly half of those cycles high. For example, W = 0x0100 gives 256 high cycles and 2 ticks in any 512 consecutive cycles.
- R8: A newly written byte takes part in the accumulator update at the next clock edge after the write, and the accumulator is not cleared by the write.
- R9: Channels are independent: writes and stepping on one channel never alter another channel's word or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 8 | Byte written into the addressed half of a control word |
| freq_out | output | NUM_CH | Variable-frequency output per channel (accumulator bit 15) |
| tick | output | NUM_CH | One-cycle strobe per channel on each rising edge of freq_out |

## Verification
The bench builds the block with two channels and an 8-bit address. With these values the random writes reach every mapped byte and also many unmapped addresses, including values that sit between or beyond the mapped slots.

The 16-bit word width lets directed runs cover the boundary words 0x0000, 0x7FFF, 0x8000, 0xFF00 and 0xFFFF. It also allows an exact check of the high count and tick count over two full periods.

Every cycle compares both channels against an accumulator model kept inside the bench, so mid-run word changes are checked for phase continuity.

// File: rtl/nco_pkg.sv
package nco_pkg;

  localparam int CW_W   = 16;
  localparam int BYTE_W = 8;

  typedef logic [CW_W-1:0] cword_t;

  // Fold the signed interpretation into a positive step.
  function automatic cword_t eff_step(input cword_t w);
    cword_t neg;
    neg = ~w + cword_t'(1);
    return w[CW_W-1] ? neg : w;
  endfunction

endpackage

// File: rtl/nco_cword_regs.sv
module nco_cword_regs
  import nco_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [BYTE_W-1:0]             wr_data,
  output logic [NUM_CH-1:0][CW_W-1:0]   cword_o
);

  localparam int HI_OFS = 8;
  localparam int LO_OFS = 12;
  localparam int STRIDE = 8;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(HI_OFS + STRIDE * g);
    localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(LO_OFS + STRIDE * g);

    logic                hi_en, lo_en;
    logic [BYTE_W-1:0]   hi_q, lo_q;

    always_comb begin
      hi_en = wr_en && (wr_addr == A_HI);
      lo_en = wr_en && (wr_addr == A_LO);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hi_q <= '0;
      end else if (hi_en) begin
        hi_q <= wr_data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_q <= '0;
      end else if (lo_en) begin
        lo_q <= wr_data;
      end
    end

    assign cword_o[g] = {hi_q, lo_q};
  end

endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc
  import nco_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  cword_t cword,
  output logic   freq_o,
  output logic   tick_o
);

  cword_t step;
  logic   step_en;
  cword_t acc_q, acc_d;
  logic   tick_q, tick_d;

  always_comb begin
    step    = eff_step(cword);
    step_en = |step;
    acc_d   = acc_q + step;
    tick_d  = step_en && !acc_q[CW_W-1] && acc_d[CW_W-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (step_en) begin
      acc_q <= acc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= 1'b0;
    end else begin
      tick_q <= tick_d;
    end
  end

  assign freq_o = acc_q[CW_W-1];
  assign tick_o = tick_q;

endmodule

// File: rtl/nco_bank.sv
module nco_bank
  import nco_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic [NUM_CH-1:0] freq_out,
  output logic [NUM_CH-1:0] tick
);

  logic [NUM_CH-1:0][CW_W-1:0] cword_w;

  nco_cword_regs #(
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .cword_o (cword_w)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_osc
    nco_phase_acc u_acc (
      .clk    (clk),
      .rst_n  (rst_n),
      .cword  (cword_w[g]),
      .freq_o (freq_out[g]),
      .tick_o (tick[g])
    );
  end

endmodule

// File: rtl/nco_bank_chk.sv
module nco_bank_chk #(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 8
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        wr_en,
  input logic [ADDR_W-1:0]           wr_addr,
  input logic [7:0]                  wr_data,
  input logic [NUM_CH-1:0]           freq_out,
  input logic [NUM_CH-1:0]           tick,
  input logic [NUM_CH-1:0][15:0]     cword
);

  logic addr_ok;
  assign addr_ok = (wr_addr[1:0] == 2'b00) &&
                   (wr_addr >= ADDR_W'(8)) &&
                   (wr_addr <  ADDR_W'(8 + 8 * NUM_CH));

  // R4: unmapped writes leave all words untouched
  p_bad_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr_ok) |=> $stable(cword));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(8 + 8 * g);
    localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(12 + 8 * g);

    // R3: high byte write
    p_msb_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == A_HI) |=>
        (cword[g][15:8] == $past(wr_data) && cword[g][7:0] == $past(cword[g][7:0])));

    // R3: low byte write
    p_lsb_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == A_LO) |=>
        (cword[g][7:0] == $past(wr_data) && cword[g][15:8] == $past(cword[g][15:8])));

    // R5: tick marks a fresh rising output
    p_tick_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
      tick[g] |-> (freq_out[g] && !$past(freq_out[g])));

    // R6: zero step holds the output
    p_zero_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cword[g] == 16'h0000) |=> ($stable(freq_out[g]) && !tick[g]));
  end

endmodule

bind nco_bank nco_bank_chk #(
  .NUM_CH (NUM_CH),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .freq_out (freq_out),
  .tick     (tick),
  .cword    (cword_w)
);

// File: tb/tb_nco_bank.sv
`timescale 1ns/1ps
module tb_nco_bank;

  localparam int NCH = 2;
  localparam int AW  = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_data;
  logic [NCH-1:0] freq_out, tick;

  always #2 clk = ~clk;

  nco_bank #(.NUM_CH(NCH), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .freq_out(freq_out), .tick(tick)
  );

  int n_chk = 0;
  int n_bad = 0;

  logic [15:0] m_cw  [NCH];
  logic [15:0] m_acc [NCH];
  logic        m_tk  [NCH];
  int hi_cnt[NCH], tk_cnt[NCH], tg_cnt[NCH];

  function automatic logic [15:0] step_of(logic [15:0] w);
    return w[15] ? 16'(~w + 16'd1) : w;
  endfunction

  function automatic bit addr_valid(logic [7:0] a);
    return (a[1:0] == 2'b00) && (a >= 8'd8) && (int'(a) < 8 + 8 * NCH);
  endfunction

  task automatic check(string tag, string what, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic clear_counts();
    for (int c = 0; c < NCH; c++) begin
      hi_cnt[c] = 0; tk_cnt[c] = 0; tg_cnt[c] = 0;
    end
  endtask

  task automatic cyc(bit we, logic [7:0] a, logic [7:0] d, string tag);
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    for (int c = 0; c < NCH; c++) begin
      logic [15:0] prev;
      prev     = m_acc[c];
      m_acc[c] = prev + step_of(m_cw[c]);
      m_tk[c]  = !prev[15] && m_acc[c][15];
      if (m_acc[c][15]) hi_cnt[c]++;
      if (m_tk[c]) tk_cnt[c]++;
      if (m_acc[c][15] != prev[15]) tg_cnt[c]++;
    end
    if (we && addr_valid(a)) begin
      int c;
      c = (int'(a) - 8) / 8;
      if (a[2]) m_cw[c][7:0] = d;
      else      m_cw[c][15:8] = d;
    end
    for (int c = 0; c < NCH; c++) begin
      check(tag, $sformatf("freq_out[%0d]", c), int'(freq_out[c]), int'(m_acc[c][15]));
      check(tag, $sformatf("tick[%0d]", c), int'(tick[c]), int'(m_tk[c]));
    end
  endtask

  task automatic idle(int n, string tag);
    for (int k = 0; k < n; k++) cyc(1'b0, 8'h00, 8'h00, tag);
  endtask

  initial begin
    #(4ns * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    for (int c = 0; c < NCH; c++) begin
      m_cw[c] = '0; m_acc[c] = '0; m_tk[c] = 1'b0;
    end
    clear_counts();
    repeat (3) @(posedge clk);
    #1;
    check("R2", "reset freq_out", int'(freq_out), 0);
    check("R2", "reset tick", int'(tick), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 / R7: 0xFF00 on channel 1 and 0x0100 on channel 0 both step by 256
    cyc(1'b1, 8'h10, 8'hFF, "R1");
    cyc(1'b1, 8'h08, 8'h01, "R3");
    clear_counts();
    idle(512, "R7");
    check("R7", "ch0 high cycles", hi_cnt[0], 256);
    check("R7", "ch0 ticks", tk_cnt[0], 2);
    check("R1", "ch1 high cycles", hi_cnt[1], 256);
    check("R1", "ch1 ticks", tk_cnt[1], 2);

    // R8: change word mid-run, phase continues
    cyc(1'b1, 8'h0C, 8'h80, "R8");
    idle(300, "R8");

    // R1 boundaries on channel 0
    cyc(1'b1, 8'h0C, 8'h00, "R1");
    cyc(1'b1, 8'h08, 8'h80, "R1");
    clear_counts();
    idle(64, "R1");
    check("R1", "0x8000 ticks", tk_cnt[0], 32);
    cyc(1'b1, 8'h0C, 8'hFF, "R1");
    cyc(1'b1, 8'h08, 8'hFF, "R1");
    idle(200, "R1");
    cyc(1'b1, 8'h08, 8'h7F, "R1");
    idle(200, "R1");

    // R6: zero step on both channels
    cyc(1'b1, 8'h08, 8'h00, "R6");
    cyc(1'b1, 8'h0C, 8'h00, "R6");
    cyc(1'b1, 8'h10, 8'h00, "R6");
    cyc(1'b1, 8'h14, 8'h00, "R6");
    clear_counts();
    idle(200, "R6");
    check("R6", "ch0 toggles", tg_cnt[0], 0);
    check("R6", "ch0 ticks", tk_cnt[0], 0);
    check("R6", "ch1 toggles", tg_cnt[1], 0);

    // R4: unmapped addresses
    clear_counts();
    cyc(1'b1, 8'h00, 8'h55, "R4");
    cyc(1'b1, 8'h04, 8'h55, "R4");
    cyc(1'b1, 8'h09, 8'h55, "R4");
    cyc(1'b1, 8'h0E, 8'h55, "R4");
    cyc(1'b1, 8'h18, 8'h55, "R4");
    cyc(1'b1, 8'h1C, 8'h55, "R4");
    cyc(1'b1, 8'hFF, 8'h55, "R4");
    idle(100, "R4");
    check("R4", "ch0 toggles", tg_cnt[0], 0);
    check("R4", "ch1 toggles", tg_cnt[1], 0);
    check("R4", "ticks", tk_cnt[0] + tk_cnt[1], 0);

    // R9: random traffic across channels
    for (int k = 0; k < 4000; k++) begin
      if (($urandom % 100) < 20) begin
        logic [7:0] a;
        if (($urandom % 4) == 0) a = 8'($urandom);
        else a = 8'(8 + 4 * ($urandom % (2 * NCH)));
        cyc(1'b1, a, 8'($urandom), "R9");
      end else begin
        cyc(1'b0, 8'h00, 8'h00, "R9");
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule